// File: doc/BRIEF.md
# Power-Mode Clock Source Steering

This block turns a requested power mode into the oscillator enables and the clock routing of a small controller. It decodes a 3-bit mode code into seven modes: primary run, primary idle, secondary run, secondary idle, internal-RC run, internal-RC idle and sleep. From that mode and three keep-alive flags it decides which oscillators run, which source drives the core, and whether the core and peripheral clock trees are active.

The keep-alive flags come from the USB function, the watchdog and the secondary timer. They can hold an oscillator on outside the modes that would normally use it. The block also gates the clock/4 level on the second oscillator pin so that the pin rests low during sleep.

All mode-dependent outputs are registered and follow a change of inputs at the next clock edge. The reset is asynchronous on assertion and is released through a two-stage synchronizer.

Top module: `pm_clk_steer`

## Requirements
- R1: While reset is held and after its release, before any mode is applied, the primary enable is 1, the secondary and RC enables are 0, the core source select is 0, and both the core and peripheral clock flags are 1.
- R2: The mode codes are 0 primary run, 1 primary idle, 2 secondary run, 3 secondary idle, 4 RC run, 5 RC idle and 6 sleep. The primary enable is 1 in codes 0 and 1, and 0 in codes 2 to 6 unless R3 applies.
- R3: When the USB enable is 1, the primary enable is 1 in every code except sleep (6). In sleep it is 0.
- R4: The core source select is 0 for primary, 1 for secondary, 2 for internal RC and 3 for none (sleep).
- R5: The secondary enable is 1 in codes 2 and 3, and in any code, including sleep, while the secondary-timer flag is 1.
- R6: The RC enable is 1 in codes 4 and 5, and in any code, including sleep, while the watchdog enable is 1.
- R7: In run codes (0, 2, 4) the core and peripheral clock flags are both 1. In idle codes (1, 3, 5) the core flag is 0 and the peripheral flag is 1. In sleep both are 0.
- R8: The unused code 7 gives exactly the outputs of code 0.
- R9: The pin output equals the clock/4 input when the pin's clock-out configuration is 1 and the registered mode is not sleep. It is 0 in sleep, and 0 when the configuration is 0.
- R10: Enables, select and clock flags change only at the first rising clock edge after the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Requested power mode code |
| usb_on_i | input | 1 | USB function enabled |
| wdog_on_i | input | 1 | Watchdog enabled |
| tmr_keep_i | input | 1 | Secondary timer needs its oscillator |
| ckout_cfg_i | input | 1 | Pin is configured to output clock/4 |
| clk4_lvl_i | input | 1 | Current clock/4 level |
| pri_en_o | output | 1 | Primary oscillator enable |
| sec_en_o | output | 1 | Secondary oscillator enable |
| rc_en_o | output | 1 | Internal RC oscillator enable |
| core_sel_o | output | 2 | Core clock source select |
| core_act_o | output | 1 | Core clock active |
| per_act_o | output | 1 | Peripheral clock active |
| pin_ckout_o | output | 1 | Clock-out pin level |

## Verification
The bench builds the block with its default widths: a 3-bit mode field and a 2-bit source select. The full mode space is therefore reachable, including the unused code 7. Each of the eight codes is applied with every keep-alive flag held low, and then with the USB, watchdog and timer flags held high, so that every enable is seen being forced on over a mode that would otherwise turn it off. The pin output is toggled within a run mode and within sleep. Separate checks look at the outputs just before and just after the first edge that follows a mode change.

// File: rtl/pm_clk_pkg.sv
package pm_clk_pkg;
  localparam int MODE_W = 3;
  localparam int SEL_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    PM_PRI_RUN  = 3'd0,
    PM_PRI_IDLE = 3'd1,
    PM_SEC_RUN  = 3'd2,
    PM_SEC_IDLE = 3'd3,
    PM_RC_RUN   = 3'd4,
    PM_RC_IDLE  = 3'd5,
    PM_SLEEP    = 3'd6
  } pm_mode_e;

  typedef enum logic [SEL_W-1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_RC  = 2'd2,
    SRC_OFF = 2'd3
  } clk_src_e;

  typedef struct packed {
    logic     pri_en;
    logic     sec_en;
    logic     rc_en;
    clk_src_e src;
    logic     core_act;
    logic     per_act;
  } clk_state_t;

  localparam clk_state_t STATE_RST = '{
    pri_en: 1'b1, sec_en: 1'b0, rc_en: 1'b0,
    src: SRC_PRI, core_act: 1'b1, per_act: 1'b1
  };
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pm_mode_decode.sv
module pm_mode_decode
  import pm_clk_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output clk_src_e          src_o,
  output logic              idle_o,
  output logic              sleep_o
);
  always_comb begin
    src_o   = SRC_PRI;
    idle_o  = 1'b0;
    sleep_o = 1'b0;
    case (mode_i)
      PM_PRI_IDLE: idle_o = 1'b1;
      PM_SEC_RUN:  src_o = SRC_SEC;
      PM_SEC_IDLE: begin src_o = SRC_SEC; idle_o = 1'b1; end
      PM_RC_RUN:   src_o = SRC_RC;
      PM_RC_IDLE:  begin src_o = SRC_RC; idle_o = 1'b1; end
      PM_SLEEP:    begin src_o = SRC_OFF; sleep_o = 1'b1; end
      default:     src_o = SRC_PRI; // run on primary, unused code included
    endcase
  end
endmodule

// File: rtl/pm_osc_enable.sv
module pm_osc_enable
  import pm_clk_pkg::*;
(
  input  clk_src_e   src_i,
  input  logic       idle_i,
  input  logic       sleep_i,
  input  logic       usb_on_i,
  input  logic       wdog_on_i,
  input  logic       tmr_keep_i,
  output clk_state_t next_o
);
  always_comb begin
    next_o.src      = src_i;
    // primary: its own modes, or held for USB in anything but sleep
    next_o.pri_en   = (src_i == SRC_PRI) || (usb_on_i && !sleep_i);
    next_o.sec_en   = (src_i == SRC_SEC) || tmr_keep_i;
    next_o.rc_en    = (src_i == SRC_RC)  || wdog_on_i;
    next_o.core_act = !idle_i && !sleep_i;
    next_o.per_act  = !sleep_i;
  end
endmodule

// File: rtl/pm_clk_steer.sv
module pm_clk_steer
  import pm_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              usb_on_i,
  input  logic              wdog_on_i,
  input  logic              tmr_keep_i,
  input  logic              ckout_cfg_i,
  input  logic              clk4_lvl_i,
  output logic              pri_en_o,
  output logic              sec_en_o,
  output logic              rc_en_o,
  output logic [SEL_W-1:0]  core_sel_o,
  output logic              core_act_o,
  output logic              per_act_o,
  output logic              pin_ckout_o
);
  logic       rst_sync_n;
  clk_src_e   dec_src;
  logic       dec_idle, dec_sleep;
  clk_state_t state_d, state_q;
  logic       upd_en;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pm_mode_decode u_dec (
    .mode_i(mode_i), .src_o(dec_src), .idle_o(dec_idle), .sleep_o(dec_sleep)
  );

  pm_osc_enable u_en (
    .src_i(dec_src), .idle_i(dec_idle), .sleep_i(dec_sleep),
    .usb_on_i(usb_on_i), .wdog_on_i(wdog_on_i), .tmr_keep_i(tmr_keep_i),
    .next_o(state_d)
  );

  assign upd_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  state_q <= STATE_RST;
    else if (upd_en)  state_q <= state_d;
  end

  assign pri_en_o    = state_q.pri_en;
  assign sec_en_o    = state_q.sec_en;
  assign rc_en_o     = state_q.rc_en;
  assign core_sel_o  = state_q.src;
  assign core_act_o  = state_q.core_act;
  assign per_act_o   = state_q.per_act;
  assign pin_ckout_o = ckout_cfg_i && (state_q.src != SRC_OFF) && clk4_lvl_i;

  a_r3_usb_holds_pri: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (usb_on_i && mode_i != PM_SLEEP) |=> pri_en_o);
  a_r5_tmr_holds_sec: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_keep_i |=> sec_en_o);
  a_r6_wdog_holds_rc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wdog_on_i |=> rc_en_o);
  a_r7_core_needs_per: assert property (@(posedge clk) disable iff (!rst_sync_n)
    core_act_o |-> per_act_o);
  a_r9_pin_low_sleep: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (core_sel_o == SRC_OFF) |-> !pin_ckout_o);
  a_r10_sleep_next_edge: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == PM_SLEEP) |=> (!per_act_o && core_sel_o == SRC_OFF));
endmodule

// File: tb/pm_clk_steer_tb_top.sv
`timescale 1ns/1ps
module pm_clk_steer_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] mode;
  logic usb, wdog, tmr, cfg, lvl;
  logic pri, sec, rc, core, per, pin;
  logic [1:0] sel;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pm_clk_steer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .usb_on_i(usb), .wdog_on_i(wdog),
    .tmr_keep_i(tmr), .ckout_cfg_i(cfg), .clk4_lvl_i(lvl),
    .pri_en_o(pri), .sec_en_o(sec), .rc_en_o(rc), .core_sel_o(sel),
    .core_act_o(core), .per_act_o(per), .pin_ckout_o(pin)
  );

  // packed output vector: {pri,sec,rc,sel[1:0],core,per}
  function automatic logic [6:0] model(input logic [2:0] m, input logic u, w, t);
    logic [1:0] s; logic id, sl;
    s = (m == 3'd2 || m == 3'd3) ? 2'd1 : (m == 3'd4 || m == 3'd5) ? 2'd2 :
        (m == 3'd6) ? 2'd3 : 2'd0;
    id = (m == 3'd1 || m == 3'd3 || m == 3'd5);
    sl = (m == 3'd6);
    return {(s == 2'd0) || (u && !sl), (s == 2'd1) || t, (s == 2'd2) || w,
            s, !id && !sl, !sl};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {pri, sec, rc, sel, core, per};
  endfunction

  task automatic apply(input logic [2:0] m, input logic u, w, t, input string req);
    logic [6:0] e;
    @(negedge clk);
    mode = m; usb = u; wdog = w; tmr = t;
    @(posedge clk); #1;
    e = model(m, u, w, t);
    chk(outs() == e, req, outs(), e);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 3'd4; usb = 0; wdog = 0; tmr = 0; cfg = 0; lvl = 0;
    repeat (3) @(posedge clk); #1;
    chk(outs() == 7'b1000011, "R1 during reset", outs(), 7'b1000011);
    mode = 3'd0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(outs() == 7'b1000011, "R1 after release", outs(), 7'b1000011);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_modes_plain();
    for (int m = 0; m < 8; m++) apply(m[2:0], 0, 0, 0, "R2 R4 R7 plain mode");
  endtask

  task automatic t_usb();
    for (int m = 0; m < 7; m++) apply(m[2:0], 1, 0, 0, "R3 usb holds primary");
    chk(pri == 1'b0, "R3 sleep drops primary", pri, 0);
  endtask

  task automatic t_keepalive();
    apply(3'd6, 0, 1, 0, "R6 wdog in sleep");
    chk(rc == 1'b1, "R6 rc on in sleep", rc, 1);
    apply(3'd6, 0, 0, 1, "R5 timer in sleep");
    chk(sec == 1'b1 && rc == 1'b0, "R5 sec on in sleep", {sec, rc}, 2'b10);
    apply(3'd0, 0, 1, 1, "R5 R6 both kept in run");
  endtask

  task automatic t_unused_code();
    logic [6:0] a7;
    apply(3'd7, 1, 1, 0, "R8 code 7");
    a7 = outs();
    apply(3'd0, 1, 1, 0, "R8 code 0");
    chk(a7 == outs(), "R8 code 7 equals code 0", a7, outs());
  endtask

  task automatic t_pin();
    apply(3'd2, 0, 0, 0, "R9 setup run");
    cfg = 1; lvl = 1; #1;
    chk(pin == 1'b1, "R9 follows high", pin, 1);
    lvl = 0; #1;
    chk(pin == 1'b0, "R9 follows low", pin, 0);
    cfg = 0; lvl = 1; #1;
    chk(pin == 1'b0, "R9 cfg off", pin, 0);
    cfg = 1;
    apply(3'd6, 0, 0, 0, "R9 enter sleep");
    lvl = 1; #1;
    chk(pin == 1'b0, "R9 low in sleep", pin, 0);
    cfg = 0; lvl = 0;
  endtask

  task automatic t_latency();
    apply(3'd0, 0, 0, 0, "R10 start");
    @(negedge clk); mode = 3'd6;
    #1;
    chk(per == 1'b1 && pri == 1'b1, "R10 unchanged before edge", {per, pri}, 2'b11);
    @(posedge clk); #1;
    chk(per == 1'b0 && pri == 1'b0, "R10 changed after edge", {per, pri}, 2'b00);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_modes_plain(); t_usb(); t_keepalive();
        t_unused_code(); t_pin(); t_latency();
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule